// File: doc/BRIEF.md
# Token-Bus Packet Transmit Framer

This block turns a packet buffer held in a byte-wide RAM into a serial frame for a token-passing network. It accepts a start request together with a frame type, a page number and the local node ID. For a data frame it reads the destination, the count field and the payload from the selected 512-byte page. It then emits a bit stream with a per-bit valid strobe that goes straight to a line encoder. The block also sends the short control frames: free-buffer enquiry, positive acknowledgement and negative acknowledgement.

Every frame opens with an alert burst of six 1 bits. After the burst come characters, each a three-bit `110` lead-in followed by eight data bits sent least significant bit first. The packet buffer follows a fixed layout. Offset 1 holds the destination ID. Offset 2 holds the count for a short packet. When long packets are allowed, a zero at offset 2 marks a long packet, and its count then sits at offset 3. The count is not a length: it is the buffer offset of the first data byte, which is 256 minus N for a short packet and 512 minus N for a long one. The framer writes its own node ID into the source field rather than using the buffer's offset 0.

Top module: `tkn_tx_framer`

## Requirements
- R1: While reset is held and after its release, `busy`, `tx_valid`, `done` and `mem_rd` are low until a start is accepted.
- R2: A start accepted in idle puts the first alert bit on `tx_valid`/`tx_bit` in the fifth cycle after the cycle `start` was sampled. The alert is six 1 bits. Each character follows as 1,1,0 and then data bits 0 to 7. From the first alert bit to the last bit of the frame one bit is valid every cycle, with no gaps.
- R3: A data frame (`frame_type` 0) sends the alert, then 01h, then `node_id` (buffer offset 0 is not used), then the byte at offset 1 twice, then the count character(s), then the data bytes, then two CRC bytes.
- R4: With `long_en` high and offset 2 equal to zero, the packet is long. The count characters are 00h followed by the byte C at offset 3, and the data bytes come from offsets C through 511, giving 512-C bytes.
- R5: Otherwise the packet is short. The single count character is the byte C at offset 2, and the data bytes come from offsets C through 255, giving 256-C bytes. With `long_en` low a zero at offset 2 is taken as C=0 and gives 256 bytes from offset 0.
- R6: The CRC is the reflected CRC-16 with polynomial x^16+x^15+x^2+1 and an initial value of zero. It covers the count characters and the data bytes in the order sent. Its low byte is sent first.
- R7: An enquiry frame (`frame_type` 1) is the alert, 85h, and the byte at offset 1 twice, with no CRC.
- R8: An acknowledgement (`frame_type` 2) is the alert and 86h. A negative acknowledgement (`frame_type` 3) is the alert and 15h.
- R9: `done` is high for exactly one cycle, the cycle right after the last frame bit. In that same cycle `tx_valid` and `busy` are low.
- R10: A `start` raised while `busy` is high, with any `frame_type`, has no effect. The current frame continues unchanged and no frame follows it.
- R11: RAM reads present `{page, offset}` on `mem_addr` with `mem_rd` high, and the byte is expected on `mem_rdata` one cycle later.
- R12: The size limits are handled exactly: short packets of 1 and 253 bytes, and long packets of 257 and 508 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; taken only when idle |
| frame_type | input | 2 | 0 data, 1 enquiry, 2 ACK, 3 NAK |
| page | input | PAGE_W | Buffer page to transmit from |
| node_id | input | 8 | Local node ID sent as source |
| long_en | input | 1 | Allow long packet interpretation |
| busy | output | 1 | Frame in progress |
| mem_rd | output | 1 | RAM read strobe |
| mem_addr | output | PAGE_W+9 | RAM byte address |
| mem_rdata | input | 8 | RAM read data, one cycle after `mem_rd` |
| tx_bit | output | 1 | Serial bit toward the line encoder |
| tx_valid | output | 1 | `tx_bit` is a frame bit this cycle |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The bench targets the long/short decision at offset 2 with `long_en` set and cleared. A design that chose wrong would send the wrong number of count characters and the wrong payload window, and the CRC would also go wrong. The four size extremes check the payload address window; an off-by-one start or end offset would shift or truncate the bit stream against the reference. The source byte is poisoned in RAM, so a design that copied offset 0 instead of inserting the node ID is exposed. A start pulsed mid-frame with a different type catches a design that restarts, re-latches its type, or queues a second frame. Stream continuity is compared every cycle, so a single stalled prefetch gap between characters shows up as a missing valid bit.

// File: rtl/tkn_tx_framer_pkg.sv
package tkn_tx_framer_pkg;

  localparam int OFF_W     = 9;   // offset inside a 512-byte page
  localparam int BYTE_W    = 8;
  localparam int ALERT_LEN = 6;
  localparam int CHR_LEN   = BYTE_W + 3;

  localparam logic [7:0] CODE_SOH = 8'h01;
  localparam logic [7:0] CODE_ENQ = 8'h85;
  localparam logic [7:0] CODE_ACK = 8'h86;
  localparam logic [7:0] CODE_NAK = 8'h15;

  typedef enum logic [1:0] {
    FT_DATA = 2'd0,
    FT_ENQ  = 2'd1,
    FT_ACK  = 2'd2,
    FT_NAK  = 2'd3
  } frame_e;

  typedef enum logic [3:0] {
    PH_ALERT, PH_TYPE, PH_SID, PH_DID1, PH_DID2,
    PH_CNT0, PH_CNT, PH_DATA, PH_CRCL, PH_CRCH, PH_END
  } phase_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RD1, S_RD2, S_RD3, S_HDR, S_SEND
  } seq_e;

  function automatic logic [7:0] type_code(frame_e t);
    case (t)
      FT_DATA: type_code = CODE_SOH;
      FT_ENQ:  type_code = CODE_ENQ;
      FT_ACK:  type_code = CODE_ACK;
      default: type_code = CODE_NAK;
    endcase
  endfunction

  function automatic phase_e next_phase(phase_e p, frame_e t, logic lng, logic more);
    case (p)
      PH_ALERT: next_phase = PH_TYPE;
      PH_TYPE:  next_phase = (t == FT_DATA) ? PH_SID :
                             (t == FT_ENQ)  ? PH_DID1 : PH_END;
      PH_SID:   next_phase = PH_DID1;
      PH_DID1:  next_phase = PH_DID2;
      PH_DID2:  next_phase = (t == FT_ENQ) ? PH_END : (lng ? PH_CNT0 : PH_CNT);
      PH_CNT0:  next_phase = PH_CNT;
      PH_CNT:   next_phase = PH_DATA;
      PH_DATA:  next_phase = more ? PH_DATA : PH_CRCL;
      PH_CRCL:  next_phase = PH_CRCH;
      default:  next_phase = PH_END;
    endcase
  endfunction

endpackage

// File: rtl/tkn_tx_crc16.sv
module tkn_tx_crc16 #(
  parameter logic [15:0] POLY_REFL = 16'hA001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] crc_q, crc_d, upd;

  always_comb begin
    upd = crc_q ^ {8'h00, din};
    for (int k = 0; k < 8; k++) begin
      upd = upd[0] ? ((upd >> 1) ^ POLY_REFL) : (upd >> 1);
    end
  end

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = '0;
    else if (en) crc_d = upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R6: a clear without update leaves a zero seed for the next frame
  a_r6_crc_seed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (crc_q == 16'h0000));

endmodule

// File: rtl/tkn_tx_shifter.sv
module tkn_tx_shifter
  import tkn_tx_framer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       ld_alert,
  input  logic [7:0] ld_byte,
  output logic       last,
  output logic       tx_bit,
  output logic       tx_valid
);

  localparam int CNT_W = $clog2(CHR_LEN + 1);

  logic [CHR_LEN-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               active;

  assign active = (cnt_q != '0);
  assign last   = (cnt_q == CNT_W'(1));

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (ld) begin
      if (ld_alert) begin
        sh_d  = '1;
        cnt_d = CNT_W'(ALERT_LEN);
      end else begin
        sh_d  = {ld_byte, 3'b011};
        cnt_d = CNT_W'(CHR_LEN);
      end
    end else if (active) begin
      sh_d  = sh_q >> 1;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign tx_bit   = sh_q[0];
  assign tx_valid = active;

  // R2: a new character may only enter at a character boundary
  a_r2_load_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> (!active || last));

  // R2: every character opens with a 1 bit of its lead-in
  a_r2_leadin_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !ld_alert) |=> (tx_valid && tx_bit));

endmodule

// File: rtl/tkn_tx_seq.sv
module tkn_tx_seq
  import tkn_tx_framer_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        frame_type,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        node_id,
  input  logic              long_en,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              ser_last,
  output logic              ld,
  output logic              ld_alert,
  output logic [7:0]        ld_byte,
  output logic              crc_clr,
  output logic              crc_en,
  input  logic [15:0]       crc,
  output logic              done
);

  localparam int REM_W = OFF_W + 1;

  seq_e              st_q, st_d;
  phase_e            ph_q, ph_d, nph;
  frame_e            typ_q, typ_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic [7:0]        node_q, node_d;
  logic              len_q, len_d;
  logic [7:0]        did_q, did_d;
  logic [7:0]        off2_q, off2_d;
  logic              lng_q, lng_d;
  logic [7:0]        cnt_q, cnt_d;
  logic [REM_W-1:0]  send_rem_q, send_rem_d;
  logic [REM_W-1:0]  fetch_rem_q, fetch_rem_d;
  logic [OFF_W-1:0]  fptr_q, fptr_d;
  logic              pf_vld_q, pf_vld_d;
  logic              rd_pend_q, rd_pend_d;
  logic [7:0]        pf_byte_q, pf_byte_d;
  logic              done_q, done_d;
  logic [OFF_W-1:0]  rd_off;
  logic              hdr_long;
  logic [7:0]        hdr_cnt;

  assign hdr_long = len_q && (off2_q == 8'h00);
  assign hdr_cnt  = hdr_long ? mem_rdata : off2_q;
  assign nph      = next_phase(ph_q, typ_q, lng_q, send_rem_q != '0);

  always_comb begin
    st_d        = st_q;
    ph_d        = ph_q;
    typ_d       = typ_q;
    page_d      = page_q;
    node_d      = node_q;
    len_d       = len_q;
    did_d       = did_q;
    off2_d      = off2_q;
    lng_d       = lng_q;
    cnt_d       = cnt_q;
    send_rem_d  = send_rem_q;
    fetch_rem_d = fetch_rem_q;
    fptr_d      = fptr_q;
    pf_vld_d    = pf_vld_q;
    rd_pend_d   = rd_pend_q;
    pf_byte_d   = pf_byte_q;
    done_d      = 1'b0;
    mem_rd      = 1'b0;
    rd_off      = '0;
    ld          = 1'b0;
    ld_alert    = 1'b0;
    ld_byte     = '0;
    crc_clr     = 1'b0;
    crc_en      = 1'b0;

    case (st_q)
      S_IDLE: begin
        if (start) begin
          st_d    = S_RD1;
          typ_d   = frame_e'(frame_type);
          page_d  = page;
          node_d  = node_id;
          len_d   = long_en;
          crc_clr = 1'b1;
        end
      end
      S_RD1: begin
        mem_rd = 1'b1;
        rd_off = OFF_W'(1);
        st_d   = S_RD2;
      end
      S_RD2: begin
        mem_rd = 1'b1;
        rd_off = OFF_W'(2);
        did_d  = mem_rdata;
        st_d   = S_RD3;
      end
      S_RD3: begin
        mem_rd = 1'b1;
        rd_off = OFF_W'(3);
        off2_d = mem_rdata;
        st_d   = S_HDR;
      end
      S_HDR: begin
        lng_d       = hdr_long;
        cnt_d       = hdr_cnt;
        send_rem_d  = (hdr_long ? REM_W'(512) : REM_W'(256)) - REM_W'(hdr_cnt);
        fetch_rem_d = (hdr_long ? REM_W'(512) : REM_W'(256)) - REM_W'(hdr_cnt);
        fptr_d      = OFF_W'(hdr_cnt);
        pf_vld_d    = 1'b0;
        rd_pend_d   = 1'b0;
        ld          = 1'b1;
        ld_alert    = 1'b1;
        ph_d        = PH_ALERT;
        st_d        = S_SEND;
      end
      S_SEND: begin
        if (rd_pend_q) begin
          pf_byte_d = mem_rdata;
          pf_vld_d  = 1'b1;
          rd_pend_d = 1'b0;
        end else if (!pf_vld_q && (fetch_rem_q != '0) && (typ_q == FT_DATA)) begin
          mem_rd      = 1'b1;
          rd_off      = fptr_q;
          rd_pend_d   = 1'b1;
          fptr_d      = fptr_q + OFF_W'(1);
          fetch_rem_d = fetch_rem_q - REM_W'(1);
        end
        if (ser_last) begin
          if (nph == PH_END) begin
            st_d   = S_IDLE;
            done_d = 1'b1;
          end else begin
            ld   = 1'b1;
            ph_d = nph;
            case (nph)
              PH_TYPE:             ld_byte = type_code(typ_q);
              PH_SID:              ld_byte = node_q;
              PH_DID1, PH_DID2:    ld_byte = did_q;
              PH_CNT0: begin
                ld_byte = 8'h00;
                crc_en  = 1'b1;
              end
              PH_CNT: begin
                ld_byte = cnt_q;
                crc_en  = 1'b1;
              end
              PH_DATA: begin
                ld_byte    = pf_byte_q;
                crc_en     = 1'b1;
                pf_vld_d   = 1'b0;
                send_rem_d = send_rem_q - REM_W'(1);
              end
              PH_CRCL:             ld_byte = crc[7:0];
              default:             ld_byte = crc[15:8];
            endcase
          end
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      ph_q        <= PH_END;
      typ_q       <= FT_DATA;
      page_q      <= '0;
      node_q      <= '0;
      len_q       <= 1'b0;
      did_q       <= '0;
      off2_q      <= '0;
      lng_q       <= 1'b0;
      cnt_q       <= '0;
      send_rem_q  <= '0;
      fetch_rem_q <= '0;
      fptr_q      <= '0;
      pf_vld_q    <= 1'b0;
      rd_pend_q   <= 1'b0;
      pf_byte_q   <= '0;
      done_q      <= 1'b0;
    end else begin
      st_q        <= st_d;
      ph_q        <= ph_d;
      typ_q       <= typ_d;
      page_q      <= page_d;
      node_q      <= node_d;
      len_q       <= len_d;
      did_q       <= did_d;
      off2_q      <= off2_d;
      lng_q       <= lng_d;
      cnt_q       <= cnt_d;
      send_rem_q  <= send_rem_d;
      fetch_rem_q <= fetch_rem_d;
      fptr_q      <= fptr_d;
      pf_vld_q    <= pf_vld_d;
      rd_pend_q   <= rd_pend_d;
      pf_byte_q   <= pf_byte_d;
      done_q      <= done_d;
    end
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = done_q;
  assign mem_addr = {page_q, rd_off};

  // R4/R5: a payload character is only loaded from a filled prefetch slot
  a_r4_payload_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && (ph_d == PH_DATA)) |-> pf_vld_q);

  // R10: a start during a frame leaves the latched frame type untouched
  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(typ_q));

  // R9: the end pulse never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/tkn_tx_framer.sv
module tkn_tx_framer
  import tkn_tx_framer_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        frame_type,
  input  logic [PAGE_W-1:0] page,
  input  logic [7:0]        node_id,
  input  logic              long_en,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              tx_bit,
  output logic              tx_valid,
  output logic              done
);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        ser_last, ld, ld_alert, crc_clr, crc_en;
  logic [7:0]  ld_byte;
  logic [15:0] crc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tkn_tx_seq #(.PAGE_W(PAGE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .frame_type (frame_type),
    .page       (page),
    .node_id    (node_id),
    .long_en    (long_en),
    .busy       (busy),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .ser_last   (ser_last),
    .ld         (ld),
    .ld_alert   (ld_alert),
    .ld_byte    (ld_byte),
    .crc_clr    (crc_clr),
    .crc_en     (crc_en),
    .crc        (crc),
    .done       (done)
  );

  tkn_tx_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ld       (ld),
    .ld_alert (ld_alert),
    .ld_byte  (ld_byte),
    .last     (ser_last),
    .tx_bit   (tx_bit),
    .tx_valid (tx_valid)
  );

  tkn_tx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (ld_byte),
    .crc   (crc)
  );

  // R9: the end pulse follows a frame bit and never overlaps one
  a_r9_done_after_bit: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> ($past(tx_valid) && !tx_valid && !busy));

  // R1: no RAM traffic and no line activity while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!busy && !done) |-> (!mem_rd && !tx_valid));

endmodule

// File: tb/tkn_tx_framer_bench.sv
module tkn_tx_framer_bench;

  localparam int PAGE_W = 2;
  localparam int ADDR_W = PAGE_W + 9;
  localparam int WDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        frame_type = 2'd0;
  logic [PAGE_W-1:0] page = '0;
  logic [7:0]        node_id = 8'h00;
  logic              long_en = 1'b0;
  logic              busy, mem_rd, tx_bit, tx_valid, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_rdata = 8'h00;

  logic [7:0] mem [0:(1<<ADDR_W)-1];
  bit         exp_q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  int         cyc = 0;
  bit         finished = 0;

  always #2.5 clk = ~clk;

  tkn_tx_framer #(.PAGE_W(PAGE_W)) u_tkn_tx_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_type(frame_type),
    .page(page), .node_id(node_id), .long_en(long_en), .busy(busy),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .done(done)
  );

  // R11: RAM model with one cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below %0d", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] b);
    logic [15:0] r = c ^ {8'h00, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  task automatic push_chr(input logic [7:0] b);
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    for (int k = 0; k < 8; k++) exp_q.push_back(b[k]);
  endtask

  // Reference frame built from the requirements
  task automatic build(input int typ, input int pg, input bit len, input logic [7:0] nid);
    int base = pg * 512;
    logic [7:0] did = mem[base + 1];
    logic [7:0] o2  = mem[base + 2];
    logic [15:0] c  = 16'h0000;
    int first, last_off;
    exp_q.delete();
    for (int k = 0; k < 6; k++) exp_q.push_back(1'b1);
    case (typ)
      0: begin
        push_chr(8'h01); push_chr(nid); push_chr(did); push_chr(did);
        if (len && o2 == 8'h00) begin
          first = mem[base + 3]; last_off = 511;
          push_chr(8'h00); c = crc_step(c, 8'h00);
          push_chr(mem[base + 3]); c = crc_step(c, mem[base + 3]);
        end else begin
          first = o2; last_off = 255;
          push_chr(o2); c = crc_step(c, o2);
        end
        for (int a = first; a <= last_off; a++) begin
          push_chr(mem[base + a]); c = crc_step(c, mem[base + a]);
        end
        push_chr(c[7:0]); push_chr(c[15:8]);
      end
      1: begin push_chr(8'h85); push_chr(did); push_chr(did); end
      2: push_chr(8'h86);
      default: push_chr(8'h15);
    endcase
  endtask

  task automatic run_frame(input int typ, input int pg, input bit len,
                           input logic [7:0] nid, input int poke, input string req);
    build(typ, pg, len, nid);
    @(negedge clk);
    start = 1'b1; frame_type = 2'(typ); page = PAGE_W'(pg); long_en = len; node_id = nid;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(!tx_valid && busy, "R2 latency", {tx_valid, busy}, 2'b01);
      @(negedge clk);
    end
    for (int i = 0; i < exp_q.size(); i++) begin
      chk(tx_valid === 1'b1 && tx_bit === exp_q[i] && !done, req,
          {tx_valid, tx_bit}, {1'b1, exp_q[i]});
      if (i == poke) begin start = 1'b1; frame_type = 2'd3; node_id = ~nid; end
      if (i == poke + 1) start = 1'b0;
      @(negedge clk);
    end
    chk(!tx_valid && done && !busy, "R9 end pulse", {tx_valid, done, busy}, 3'b010);
    @(negedge clk);
    chk(!done, "R9 single pulse", done, 0);
  endtask

  initial begin
    for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = 8'((a * 37 + 5) ^ (a >> 3));
    for (int p = 0; p < 4; p++) mem[p * 512] = 8'hEE;  // poisoned source byte

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !tx_valid && !done && !mem_rd, "R1 in reset", {busy, tx_valid, done, mem_rd}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy && !tx_valid && !done && !mem_rd, "R1 after release", {busy, tx_valid, done, mem_rd}, 0);

    // R3 R6: short data frame, 16 bytes
    mem[2] = 8'hF0;
    run_frame(0, 0, 1'b1, 8'h2A, -1, "R3 R6 short frame");
    // R12 R5: one byte short
    mem[512 + 2] = 8'hFF;
    run_frame(0, 1, 1'b1, 8'h11, -1, "R12 R5 one byte");
    // R12 R5: 253 bytes short
    mem[1024 + 2] = 8'h03;
    run_frame(0, 2, 1'b1, 8'hC3, -1, "R12 R5 253 bytes");
    // R4 R12: long 257 bytes
    mem[1536 + 2] = 8'h00; mem[1536 + 3] = 8'hFF;
    run_frame(0, 3, 1'b1, 8'h7E, -1, "R4 R12 257 bytes");
    // R4 R12 R6: long 508 bytes
    mem[2] = 8'h00; mem[3] = 8'h04;
    run_frame(0, 0, 1'b1, 8'h01, -1, "R4 R12 R6 508 bytes");
    // R5: long disabled, zero count means 256 bytes from offset 0
    run_frame(0, 0, 1'b0, 8'h55, -1, "R5 long disabled");
    // R7: enquiry
    run_frame(1, 2, 1'b1, 8'h40, -1, "R7 enquiry");
    // R8: ack and nak
    run_frame(2, 1, 1'b0, 8'h40, -1, "R8 ack");
    run_frame(3, 3, 1'b0, 8'h40, -1, "R8 nak");
    // R10: start during a frame is ignored
    mem[512 + 2] = 8'hF8;
    run_frame(0, 1, 1'b1, 8'h99, 40, "R10 start while busy");
    for (int k = 0; k < 20; k++) begin
      chk(!tx_valid && !busy && !mem_rd, "R10 no second frame", {tx_valid, busy, mem_rd}, 0);
      @(negedge clk);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule